// File: doc/BRIEF.md
# Multi-Channel Edge-Aligned PWM Timer

This block generates several pulse-width-modulated outputs from one shared time base. A single up-counter, clocked through a power-of-two prescaler, counts from zero up to a programmable period value and then wraps. Every channel compares that shared count against its own compare value, so all channels have the same period and each has its own duty. A small synchronous register bus sets up the block. Each write is one clock cycle long. Reads are combinational.

The period and compare registers have double buffering. While the counter is stopped, a write takes effect at once. While the counter is running, a write lands in a shadow copy. All shadow copies move into the active registers together, in the clock cycle in which the counter wraps. Reads always return the active value, so software can poll until a buffered write shows up in the readback. Channel configuration (enable, mode and polarity) is not buffered and acts on the output in the next cycle.

Top module: `pwmTimer`

## Requirements
- R1: After reset, every register reads zero, the counter is zero and every PWM output is low.
- R2: The control register sits at address 0. Bits [1:0] are the run field and bits [4:2] are the prescale field. A run field of 00 holds the counter at its current value. Any nonzero run field lets it count.
- R3: While the counter runs with prescale value PS (0 to 7), the count advances once every 2^PS clock cycles. The prescale divider clears while the counter is stopped.
- R4: The count reads back at address 2. It goes from 0 up to the active period value inclusive. On the step after the count reaches or passes the period, it wraps to 0. One count serves all channels.
- R5: While stopped, a write to the period register (address 1) or to the compare register of channel n (address 4+NUM_CH+n) reads back, and is in use, from the next cycle.
- R6: While running, a period or compare write is held in a shadow copy. The active value and its readback keep the old value until the next wrap cycle. In that cycle all shadow copies load together. A write that falls in the wrap cycle itself is used from that wrap.
- R7: The configuration of channel n sits at address 4+n, with bits [3:0] = {modeB, modeA, level[1:0]}. The code 4'b1010 is normal edge-aligned polarity: the output is high while count < compare. A compare of 0 keeps the output low. A compare above the period keeps it high.
- R8: The code 4'b1001 is inverted edge-aligned polarity: the output is the complement of the normal-polarity output.
- R9: Any other configuration code, including 0, holds the output low. A configuration write changes the output in the next cycle, without waiting for a wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| busWrEn | input | 1 | Register write strobe, one cycle per write |
| busAddr | input | ADDR_W | Register address for reads and writes |
| busWrData | input | DATA_W | Write data |
| busRdData | output | DATA_W | Combinational read data for busAddr |
| pwmOut | output | NUM_CH | One PWM output per channel |

## Verification
The hardest case to reach is a period or compare write that lands while the counter runs. The bench has to see the old value in the readback, and then see every channel switch at the same wrap, including a write that falls in the wrap cycle itself. The random stimulus uses small period values and low prescale settings, so wraps come every few cycles. It writes at random gaps, which makes writes keep colliding with wrap cycles. A cycle-accurate bench model tracks the expected shadow and active values, and every register is read back after each step. Directed sequences cover the stop-then-run start, a buffered period change read back before and after the wrap, compare values above the period, and disabling a channel while it is active.

// File: rtl/pwmTimerPkg.sv
package pwmTimerPkg;
  localparam int PS_W  = 3;
  localparam int RUN_W = 2;
  localparam int CFG_W = 4;
  localparam int PRE_W = (1 << PS_W) - 1;

  localparam logic [CFG_W-1:0] CFG_EDGE_NORMAL   = 4'b1010;
  localparam logic [CFG_W-1:0] CFG_EDGE_INVERTED = 4'b1001;

  typedef struct packed {
    logic            run;
    logic [PS_W-1:0] prescale;
  } timerCtrlT;
endpackage

// File: rtl/pwmRegCtrl.sv
module pwmRegCtrl
  import pwmTimerPkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    busWrEn,
  input  logic [ADDR_W-1:0]       busAddr,
  input  logic [DATA_W-1:0]       busWrData,
  output logic [DATA_W-1:0]       busRdData,
  input  logic                    periodEnd,
  input  logic [CNT_W-1:0]        cntValue,
  output timerCtrlT               ctlBus,
  output logic                    modWr,
  output logic [CNT_W-1:0]        activeMod,
  output logic [NUM_CH*CNT_W-1:0] activeCmp,
  output logic [NUM_CH*CFG_W-1:0] chCfg
);
  localparam int ADDR_CTRL = 0;
  localparam int ADDR_MOD  = 1;
  localparam int ADDR_CNT  = 2;
  localparam int CFG_BASE  = 4;
  localparam int CMP_BASE  = CFG_BASE + NUM_CH;

  logic [RUN_W-1:0] runMode;
  logic [PS_W-1:0]  psSel;
  logic [CNT_W-1:0] modBuf;
  logic             ctrlWr;
  logic             loadNow;

  assign ctrlWr  = busWrEn && (busAddr == ADDR_W'(ADDR_CTRL));
  assign modWr   = busWrEn && (busAddr == ADDR_W'(ADDR_MOD));
  // A write reaches the active copy directly when stopped or on the wrap cycle
  assign loadNow = !ctlBus.run || periodEnd;

  assign ctlBus.run      = |runMode;
  assign ctlBus.prescale = psSel;

  always_ff @(posedge clk) begin
    if (rst) begin
      runMode   <= '0;
      psSel     <= '0;
      modBuf    <= '0;
      activeMod <= '0;
    end else begin
      if (ctrlWr) begin
        runMode <= busWrData[RUN_W-1:0];
        psSel   <= busWrData[RUN_W +: PS_W];
      end
      if (periodEnd) activeMod <= modBuf;
      if (modWr) begin
        modBuf <= busWrData[CNT_W-1:0];
        if (loadNow) activeMod <= busWrData[CNT_W-1:0];
      end
    end
  end

  logic [CNT_W-1:0] cmpAct [NUM_CH];
  logic [CFG_W-1:0] cfgReg [NUM_CH];

  for (genvar i = 0; i < NUM_CH; i++) begin : gChan
    logic             cmpWr;
    logic             cfgWr;
    logic [CNT_W-1:0] cmpBuf;

    assign cmpWr = busWrEn && (busAddr == ADDR_W'(CMP_BASE + i));
    assign cfgWr = busWrEn && (busAddr == ADDR_W'(CFG_BASE + i));

    always_ff @(posedge clk) begin
      if (rst) begin
        cmpBuf    <= '0;
        cmpAct[i] <= '0;
        cfgReg[i] <= '0;
      end else begin
        if (cfgWr) cfgReg[i] <= busWrData[CFG_W-1:0];
        if (periodEnd) cmpAct[i] <= cmpBuf;
        if (cmpWr) begin
          cmpBuf <= busWrData[CNT_W-1:0];
          if (loadNow) cmpAct[i] <= busWrData[CNT_W-1:0];
        end
      end
    end

    assign activeCmp[i*CNT_W +: CNT_W] = cmpAct[i];
    assign chCfg[i*CFG_W +: CFG_W]     = cfgReg[i];
  end

  always_comb begin
    busRdData = '0;
    if (busAddr == ADDR_W'(ADDR_CTRL)) busRdData = DATA_W'({psSel, runMode});
    if (busAddr == ADDR_W'(ADDR_MOD))  busRdData = DATA_W'(activeMod);
    if (busAddr == ADDR_W'(ADDR_CNT))  busRdData = DATA_W'(cntValue);
    for (int i = 0; i < NUM_CH; i++) begin
      if (busAddr == ADDR_W'(CFG_BASE + i)) busRdData = DATA_W'(cfgReg[i]);
      if (busAddr == ADDR_W'(CMP_BASE + i)) busRdData = DATA_W'(cmpAct[i]);
    end
  end
endmodule

// File: rtl/pwmCountPath.sv
module pwmCountPath
  import pwmTimerPkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  timerCtrlT               ctlBus,
  input  logic [CNT_W-1:0]        activeMod,
  input  logic [NUM_CH*CNT_W-1:0] activeCmp,
  input  logic [NUM_CH*CFG_W-1:0] chCfg,
  output logic [CNT_W-1:0]        cntValue,
  output logic                    periodEnd,
  output logic [NUM_CH-1:0]       pwmOut
);
  logic [PRE_W-1:0] preCnt;
  logic [PRE_W-1:0] preMask;
  logic             tick;

  // Low PS bits of the free-running divider all ones marks a count step
  assign preMask   = ~({PRE_W{1'b1}} << ctlBus.prescale);
  assign tick      = ctlBus.run && ((preCnt & preMask) == preMask);
  assign periodEnd = tick && (cntValue >= activeMod);

  always_ff @(posedge clk) begin
    if (rst) begin
      preCnt   <= '0;
      cntValue <= '0;
    end else begin
      preCnt <= ctlBus.run ? preCnt + 1'b1 : '0;
      if (tick) cntValue <= periodEnd ? '0 : cntValue + 1'b1;
    end
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : gOut
    logic [CFG_W-1:0] cfg;
    logic             rawHigh;

    assign cfg     = chCfg[i*CFG_W +: CFG_W];
    assign rawHigh = cntValue < activeCmp[i*CNT_W +: CNT_W];

    always_comb begin
      unique case (cfg)
        CFG_EDGE_NORMAL:   pwmOut[i] = rawHigh;
        CFG_EDGE_INVERTED: pwmOut[i] = !rawHigh;
        default:           pwmOut[i] = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/pwmTimer.sv
module pwmTimer
  import pwmTimerPkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  output logic [NUM_CH-1:0] pwmOut
);
  timerCtrlT               ctlBus;
  logic                    modWr;
  logic                    periodEnd;
  logic [CNT_W-1:0]        cntValue;
  logic [CNT_W-1:0]        activeMod;
  logic [NUM_CH*CNT_W-1:0] activeCmp;
  logic [NUM_CH*CFG_W-1:0] chCfg;

  pwmRegCtrl #(
    .NUM_CH(NUM_CH), .CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
  ) uCtrl (
    .clk(clk), .rst(rst),
    .busWrEn(busWrEn), .busAddr(busAddr), .busWrData(busWrData),
    .busRdData(busRdData),
    .periodEnd(periodEnd), .cntValue(cntValue),
    .ctlBus(ctlBus), .modWr(modWr),
    .activeMod(activeMod), .activeCmp(activeCmp), .chCfg(chCfg)
  );

  pwmCountPath #(
    .NUM_CH(NUM_CH), .CNT_W(CNT_W)
  ) uPath (
    .clk(clk), .rst(rst),
    .ctlBus(ctlBus), .activeMod(activeMod), .activeCmp(activeCmp),
    .chCfg(chCfg),
    .cntValue(cntValue), .periodEnd(periodEnd), .pwmOut(pwmOut)
  );
endmodule

// File: rtl/pwmTimerChecker.sv
module pwmTimerChecker
  import pwmTimerPkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 16
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    runNow,
  input logic                    periodEnd,
  input logic                    modWr,
  input logic [CNT_W-1:0]        cntValue,
  input logic [CNT_W-1:0]        activeMod,
  input logic [NUM_CH*CNT_W-1:0] activeCmp,
  input logic [NUM_CH*CFG_W-1:0] chCfg,
  input logic [NUM_CH-1:0]       pwmOut
);
  a_r2_stop_holds: assert property (@(posedge clk) disable iff (rst)
    !runNow |=> $stable(cntValue));

  a_r4_count_steps: assert property (@(posedge clk) disable iff (rst)
    (cntValue != $past(cntValue)) |->
      (cntValue == '0 || cntValue == $past(cntValue) + 1'b1));

  a_r6_mod_held: assert property (@(posedge clk) disable iff (rst)
    (!modWr && !periodEnd) |=> $stable(activeMod));

  for (genvar i = 0; i < NUM_CH; i++) begin : gChk
    a_r9_disabled_low: assert property (@(posedge clk) disable iff (rst)
      (chCfg[i*CFG_W +: CFG_W] == '0) |-> !pwmOut[i]);

    a_r7_zero_duty_low: assert property (@(posedge clk) disable iff (rst)
      (chCfg[i*CFG_W +: CFG_W] == CFG_EDGE_NORMAL &&
       activeCmp[i*CNT_W +: CNT_W] == '0) |-> !pwmOut[i]);

    a_r8_zero_duty_high: assert property (@(posedge clk) disable iff (rst)
      (chCfg[i*CFG_W +: CFG_W] == CFG_EDGE_INVERTED &&
       activeCmp[i*CNT_W +: CNT_W] == '0) |-> pwmOut[i]);
  end
endmodule

bind pwmTimer pwmTimerChecker #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) uChk (
  .clk(clk), .rst(rst), .runNow(ctlBus.run), .periodEnd(periodEnd),
  .modWr(modWr), .cntValue(cntValue), .activeMod(activeMod),
  .activeCmp(activeCmp), .chCfg(chCfg), .pwmOut(pwmOut)
);

// File: tb/tb_pwmTimer.sv
`timescale 1ns/10ps
module tb_pwmTimer;
  localparam int NCH = 4;
  localparam int A_CTRL = 0, A_MOD = 1, A_CNT = 2, A_CFG = 4, A_CMP = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        busWrEn = 1'b0;
  logic [3:0]  busAddr = '0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic [NCH-1:0] pwmOut;

  int nTests = 0;
  int nFail  = 0;
  int cycles = 0;
  bit chkEn  = 1'b0;

  always #5 clk = ~clk;

  pwmTimer dut (
    .clk(clk), .rst(rst), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .pwmOut(pwmOut)
  );

  // Bench model built from the requirements
  logic [4:0]  mCtrl;
  logic [15:0] mMod, mModBuf, mCnt;
  logic [6:0]  mPre;
  logic [15:0] mCmp [NCH];
  logic [15:0] mCmpBuf [NCH];
  logic [3:0]  mCfg [NCH];
  logic        mRun, mTick, mEnd;
  logic [6:0]  mMask;

  always_comb begin
    mRun  = mCtrl[1:0] != 2'b00;
    mMask = ~(7'h7F << mCtrl[4:2]);
    mTick = mRun && ((mPre & mMask) == mMask);
    mEnd  = mTick && (mCnt >= mMod);
  end

  always @(posedge clk) begin
    if (rst) begin
      mCtrl <= '0; mMod <= '0; mModBuf <= '0; mCnt <= '0; mPre <= '0;
      for (int c = 0; c < NCH; c++) begin
        mCmp[c] <= '0; mCmpBuf[c] <= '0; mCfg[c] <= '0;
      end
    end else begin
      mPre <= mRun ? mPre + 7'd1 : 7'd0;
      if (mTick) mCnt <= mEnd ? 16'd0 : mCnt + 16'd1;
      if (mEnd) begin
        mMod <= mModBuf;
        for (int c = 0; c < NCH; c++) mCmp[c] <= mCmpBuf[c];
      end
      if (busWrEn) begin
        if (busAddr == A_CTRL) mCtrl <= busWrData[4:0];
        if (busAddr == A_MOD) begin
          mModBuf <= busWrData[15:0];
          if (!mRun || mEnd) mMod <= busWrData[15:0];
        end
        for (int c = 0; c < NCH; c++) begin
          if (busAddr == 4'(A_CFG + c)) mCfg[c] <= busWrData[3:0];
          if (busAddr == 4'(A_CMP + c)) begin
            mCmpBuf[c] <= busWrData[15:0];
            if (!mRun || mEnd) mCmp[c] <= busWrData[15:0];
          end
        end
      end
    end
  end

  function automatic logic expPwm(int c);
    logic raw;
    raw = mCnt < mCmp[c];
    case (mCfg[c])
      4'hA:    return raw;
      4'h9:    return !raw;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string pwmTag(int c);
    case (mCfg[c])
      4'hA:    return "R7";
      4'h9:    return "R8";
      default: return "R9";
    endcase
  endfunction

  // Output monitor, away from the active edge
  always @(negedge clk) begin
    if (chkEn && !rst) begin
      for (int c = 0; c < NCH; c++) begin
        nTests++;
        if (pwmOut[c] !== expPwm(c)) begin
          nFail++;
          $display("FAIL %s pwmOut[%0d] actual %b expected %b (cnt %0d cmp %0d cfg %h)",
                   pwmTag(c), c, pwmOut[c], expPwm(c), mCnt, mCmp[c], mCfg[c]);
        end
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      nFail++;
      $display("FAIL watchdog expired, actual %0d cycles expected fewer", cycles);
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  task automatic wr(input int addr, input logic [31:0] data);
    busWrEn   = 1'b1;
    busAddr   = 4'(addr);
    busWrData = data;
    @(negedge clk);
    busWrEn   = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic readChk(input int addr, input logic [31:0] exp, input string tag);
    busAddr = 4'(addr);
    #0.3;
    nTests++;
    if (busRdData !== exp) begin
      nFail++;
      $display("FAIL %s read addr %0d actual %0h expected %0h", tag, addr, busRdData, exp);
    end
  endtask

  task automatic readAll();
    readChk(A_CTRL, 32'(mCtrl), "R2");
    readChk(A_MOD, 32'(mMod), "R5/R6");
    readChk(A_CNT, 32'(mCnt), "R3/R4");
    for (int c = 0; c < NCH; c++) begin
      readChk(A_CFG + c, 32'(mCfg[c]), "R9");
      readChk(A_CMP + c, 32'(mCmp[c]), "R5/R6");
    end
  endtask

  task automatic pinChk(input int c, input logic exp, input string tag);
    nTests++;
    if (pwmOut[c] !== exp) begin
      nFail++;
      $display("FAIL %s pin %0d actual %b expected %b", tag, c, pwmOut[c], exp);
    end
  endtask

  function automatic logic [31:0] randCfg();
    case ($urandom_range(0, 3))
      0: return 32'h0;
      1: return 32'hA;
      2: return 32'h9;
      default: return 32'($urandom_range(0, 15));
    endcase
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    idle(3);
    rst = 1'b0;
    @(negedge clk);
    chkEn = 1'b1;

    // R1: reset state
    readChk(A_MOD, 32'd0, "R1");
    readChk(A_CNT, 32'd0, "R1");
    readChk(A_CTRL, 32'd0, "R1");
    pinChk(0, 1'b0, "R1");

    // R5: immediate writes while stopped
    wr(A_MOD, 32'd9);
    readChk(A_MOD, 32'd9, "R5");
    wr(A_CMP, 32'd4);
    readChk(A_CMP, 32'd4, "R5");
    wr(A_CFG, 32'hA);
    pinChk(0, 1'b1, "R7");
    idle(3);
    readChk(A_CNT, 32'd0, "R2");

    // R6: buffered period while running
    wr(A_CTRL, 32'd1);
    wr(A_MOD, 32'd2);
    readChk(A_MOD, 32'd9, "R6");
    readChk(A_CNT, 32'd1, "R4");
    idle(12);
    readChk(A_MOD, 32'd2, "R6");
    readAll();

    // R3: prescale of 4, compare above period gives full duty
    wr(A_CTRL, 32'h9);
    wr(A_CMP, 32'd20);
    idle(30);
    readAll();
    for (int k = 0; k < 10; k++) begin
      pinChk(0, 1'b1, "R7");
      @(negedge clk);
    end

    // R9: disabling acts at once
    wr(A_CFG, 32'h0);
    pinChk(0, 1'b0, "R9");
    wr(A_CFG, 32'h9);
    wr(A_CMP, 32'd0);
    idle(30);
    pinChk(0, 1'b1, "R8");
    readAll();

    // Random mix
    for (int it = 0; it < 400; it++) begin
      int sel;
      sel = $urandom_range(0, 9);
      if (sel == 0)
        wr(A_CTRL, 32'(($urandom_range(0, 9) < 8 ? $urandom_range(1, 3) : 0) |
                       ($urandom_range(0, 2) << 2)));
      else if (sel <= 3)
        wr(A_MOD, 32'($urandom_range(0, 12)));
      else if (sel <= 6)
        wr(A_CMP + $urandom_range(0, NCH - 1), 32'($urandom_range(0, 15)));
      else
        wr(A_CFG + $urandom_range(0, NCH - 1), randCfg());
      idle($urandom_range(0, 8));
      readAll();
    end

    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule